// File: doc/BRIEF.md
# Program Counter with Circular Return Stack

This block sequences instruction fetch for a core with 14-bit instruction words. It keeps a 13-bit program counter and decides its next value each cycle from a small set of control strobes. These strobes cover sequential advance, a software write of the low byte, a direct jump, a subroutine call, a return and interrupt vectoring. A 5-bit holding latch, written by software, supplies the upper PC bits. It is used in two ways. A low-byte write takes all five latch bits into PC[12:8]. A jump or call takes only the two latch bits [4:3] into PC[12:11], because the opcode field already fills PC[10:0].

Return addresses live in an 8-entry ring of 13-bit words. The ring pointer is not visible outside the block, and nothing reports overflow or underflow. A push past the eighth entry silently replaces the oldest address. A pop always returns the entry below the pointer, and the pointer steps back modulo the depth. The fetch address sent to the program memory is the PC truncated to the implemented 2K-word space, so higher addresses alias onto the implemented memory.

The reset input is asynchronous and active low. Inside the block it is released synchronously through a short synchronizer, so the block leaves reset two clock edges after `rst_n` rises.

Top module: `pc_ring_ctrl`

## Requirements
- R1: While reset is active, and after it is released until the first operation, the PC reads 0x0000 and the holding latch reads 0.
- R2: A step strobe alone advances the PC by one on the next edge. 0x1FFF advances to 0x0000.
- R3: A low-byte write alone loads PC[7:0] from the data input and PC[12:8] from latch bits [4:0].
- R4: A jump loads PC[10:0] from the opcode field and PC[12:11] from latch bits [4:3]. It pushes nothing onto the return ring.
- R5: A call loads the same target as a jump and pushes the current PC plus one onto the ring.
- R6: An interrupt strobe loads the PC with 0x0004 and pushes the current, not yet executed PC.
- R7: A return loads the full 13-bit PC from the ring top. Neither a push nor a pop changes the holding latch.
- R8: The ring holds 8 entries. A ninth push overwrites the first entry, and the pointer wraps modulo 8 on both push and pop. Nine calls followed by nine returns give back push 9, then pushes 8 down to 2, then push 9 again.
- R9: The fetch address equals PC[10:0].
- R10: When several strobes are active together, only the highest takes effect. The order is interrupt, then return, then call, then jump, then low-byte write, then step.
- R11: A latch write does not move the PC. With no strobe active, the PC holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_wr_i | input | 1 | Write the upper-bit holding latch |
| hi_data_i | input | 5 | Value for the holding latch |
| step_i | input | 1 | Advance PC by one |
| lo_wr_i | input | 1 | Instruction writes the PC low byte |
| lo_data_i | input | 8 | ALU result for the low-byte write |
| jump_i | input | 1 | Direct jump |
| call_i | input | 1 | Subroutine call |
| op_field_i | input | 11 | Target field from the opcode |
| ret_i | input | 1 | Return (any kind) |
| irq_i | input | 1 | Vector to the interrupt entry |
| pc_o | output | 13 | Current program counter |
| fetch_addr_o | output | 11 | Address sent to program memory |

## Verification
The assertions check every cycle that each isolated operation produces its target on the next edge. Sequential advance, low-byte load, jump and call targets, the fixed interrupt vector, holding when idle and the latch staying unchanged across returns are all covered this way. Return values and ring wraparound depend on what was pushed many cycles earlier. The same holds for the page bits taken from a previously written latch and for priority among simultaneous strobes. Only the bench's directed call, return and interrupt sequences show these behaviours.

// File: rtl/pc_ring_pkg.sv
package pc_ring_pkg;

  // Next-PC source, listed from lowest to highest priority
  typedef enum logic [2:0] {
    SEL_HOLD = 3'd0,
    SEL_STEP = 3'd1,
    SEL_LOWR = 3'd2,
    SEL_JUMP = 3'd3,
    SEL_CALL = 3'd4,
    SEL_RET  = 3'd5,
    SEL_IRQ  = 3'd6
  } pc_sel_e;

endpackage

// File: rtl/pc_ring_rst_sync.sv
module pc_ring_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/pc_ring_stack.sv
module pc_ring_stack #(
  parameter int PC_W  = 13,
  parameter int DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_i,
  input  logic [PC_W-1:0] push_data_i,
  input  logic            pop_i,
  output logic [PC_W-1:0] top_o
);

  localparam int PTR_W = $clog2(DEPTH);

  logic [PTR_W-1:0] sp_q;
  logic [PTR_W-1:0] sp_d;
  logic [PTR_W-1:0] rd_idx;
  logic [PC_W-1:0]  ent_q [DEPTH];

  // Pointer wraps naturally: DEPTH is a power of two
  always_comb begin
    sp_d = sp_q;
    if (push_i) begin
      sp_d = sp_q + 1'b1;
    end else if (pop_i) begin
      sp_d = sp_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= '0;
    end else begin
      sp_q <= sp_d;
    end
  end

  // Storage entries carry no reset, like a register-file macro
  always_ff @(posedge clk) begin
    if (push_i) begin
      ent_q[sp_q] <= push_data_i;
    end
  end

  always_comb begin
    rd_idx = sp_q - 1'b1;
    top_o  = ent_q[rd_idx];
  end

endmodule

// File: rtl/pc_ring_next.sv
module pc_ring_next
  import pc_ring_pkg::*;
#(
  parameter int              PC_W    = 13,
  parameter int              HI_W    = 5,
  parameter int              OP_W    = 11,
  parameter logic [PC_W-1:0] IRQ_VEC = 13'h0004
) (
  input  logic            step_i,
  input  logic            lo_wr_i,
  input  logic            jump_i,
  input  logic            call_i,
  input  logic            ret_i,
  input  logic            irq_i,
  input  logic [PC_W-1:0] pc_q_i,
  input  logic [HI_W-1:0] hi_q_i,
  input  logic [PC_W-HI_W-1:0] lo_data_i,
  input  logic [OP_W-1:0] op_field_i,
  input  logic [PC_W-1:0] stack_top_i,
  output logic [PC_W-1:0] pc_d_o,
  output logic            push_o,
  output logic [PC_W-1:0] push_data_o,
  output logic            pop_o
);

  localparam int PAGE_W = PC_W - OP_W;

  pc_sel_e         sel;
  logic [PC_W-1:0] pc_inc;
  logic [PC_W-1:0] branch_tgt;

  always_comb begin
    if (irq_i)        sel = SEL_IRQ;
    else if (ret_i)   sel = SEL_RET;
    else if (call_i)  sel = SEL_CALL;
    else if (jump_i)  sel = SEL_JUMP;
    else if (lo_wr_i) sel = SEL_LOWR;
    else if (step_i)  sel = SEL_STEP;
    else              sel = SEL_HOLD;
  end

  always_comb begin
    pc_inc     = pc_q_i + 1'b1;
    branch_tgt = {hi_q_i[HI_W-1 -: PAGE_W], op_field_i};
  end

  always_comb begin
    pc_d_o      = pc_q_i;
    push_o      = 1'b0;
    push_data_o = pc_inc;
    pop_o       = 1'b0;
    unique case (sel)
      SEL_IRQ: begin
        pc_d_o      = IRQ_VEC;
        push_o      = 1'b1;
        push_data_o = pc_q_i;
      end
      SEL_RET: begin
        pc_d_o = stack_top_i;
        pop_o  = 1'b1;
      end
      SEL_CALL: begin
        pc_d_o      = branch_tgt;
        push_o      = 1'b1;
        push_data_o = pc_inc;
      end
      SEL_JUMP: pc_d_o = branch_tgt;
      SEL_LOWR: pc_d_o = {hi_q_i, lo_data_i};
      SEL_STEP: pc_d_o = pc_inc;
      default:  pc_d_o = pc_q_i;
    endcase
  end

endmodule

// File: rtl/pc_ring_ctrl.sv
module pc_ring_ctrl #(
  parameter int                  PC_W    = 13,
  parameter int                  HI_W    = 5,
  parameter int                  OP_W    = 11,
  parameter int                  MEM_AW  = 11,
  parameter int                  DEPTH   = 8,
  parameter logic [PC_W-1:0]     IRQ_VEC = 13'h0004
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   hi_wr_i,
  input  logic [HI_W-1:0]        hi_data_i,
  input  logic                   step_i,
  input  logic                   lo_wr_i,
  input  logic [PC_W-HI_W-1:0]   lo_data_i,
  input  logic                   jump_i,
  input  logic                   call_i,
  input  logic [OP_W-1:0]        op_field_i,
  input  logic                   ret_i,
  input  logic                   irq_i,
  output logic [PC_W-1:0]        pc_o,
  output logic [MEM_AW-1:0]      fetch_addr_o
);

  logic            rst_sync_n;
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_d;
  logic [HI_W-1:0] hi_q;
  logic [HI_W-1:0] hi_d;
  logic            push;
  logic            pop;
  logic [PC_W-1:0] push_data;
  logic [PC_W-1:0] stack_top;

  pc_ring_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pc_ring_next #(
    .PC_W    (PC_W),
    .HI_W    (HI_W),
    .OP_W    (OP_W),
    .IRQ_VEC (IRQ_VEC)
  ) next_i (
    .step_i      (step_i),
    .lo_wr_i     (lo_wr_i),
    .jump_i      (jump_i),
    .call_i      (call_i),
    .ret_i       (ret_i),
    .irq_i       (irq_i),
    .pc_q_i      (pc_q),
    .hi_q_i      (hi_q),
    .lo_data_i   (lo_data_i),
    .op_field_i  (op_field_i),
    .stack_top_i (stack_top),
    .pc_d_o      (pc_d),
    .push_o      (push),
    .push_data_o (push_data),
    .pop_o       (pop)
  );

  pc_ring_stack #(
    .PC_W  (PC_W),
    .DEPTH (DEPTH)
  ) stack_i (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .push_i      (push),
    .push_data_i (push_data),
    .pop_i       (pop),
    .top_o       (stack_top)
  );

  // Holding latch is touched only by its own write strobe
  always_comb begin
    hi_d = hi_q;
    if (hi_wr_i) begin
      hi_d = hi_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pc_q <= '0;
      hi_q <= '0;
    end else begin
      pc_q <= pc_d;
      hi_q <= hi_d;
    end
  end

  assign pc_o         = pc_q;
  assign fetch_addr_o = pc_q[MEM_AW-1:0];

endmodule

// File: rtl/pc_ring_ctrl_chk.sv
module pc_ring_ctrl_chk #(
  parameter int              PC_W    = 13,
  parameter int              HI_W    = 5,
  parameter int              OP_W    = 11,
  parameter logic [PC_W-1:0] IRQ_VEC = 13'h0004
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 hi_wr_i,
  input logic                 step_i,
  input logic                 lo_wr_i,
  input logic [PC_W-HI_W-1:0] lo_data_i,
  input logic                 jump_i,
  input logic                 call_i,
  input logic [OP_W-1:0]      op_field_i,
  input logic                 ret_i,
  input logic                 irq_i,
  input logic [PC_W-1:0]      pc,
  input logic [HI_W-1:0]      hi
);

  logic any_branch;
  assign any_branch = irq_i | ret_i | call_i | jump_i;

  AST_STEP_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !lo_wr_i && !any_branch) |=> pc == PC_W'($past(pc) + 1'b1)); // R2

  AST_LOWR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_wr_i && !any_branch) |=> pc == {$past(hi), $past(lo_data_i)}); // R3

  AST_JUMP_TGT: assert property (@(posedge clk) disable iff (!rst_n)
    (jump_i && !call_i && !ret_i && !irq_i) |=> pc[OP_W-1:0] == $past(op_field_i)); // R4

  AST_CALL_TGT: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && !ret_i && !irq_i) |=> pc[OP_W-1:0] == $past(op_field_i)); // R5

  AST_IRQ_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    irq_i |=> pc == IRQ_VEC); // R6

  AST_RET_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ((ret_i || call_i || irq_i) && !hi_wr_i) |=> $stable(hi)); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !lo_wr_i && !any_branch) |=> $stable(pc)); // R11

endmodule

bind pc_ring_ctrl pc_ring_ctrl_chk #(
  .PC_W    (PC_W),
  .HI_W    (HI_W),
  .OP_W    (OP_W),
  .IRQ_VEC (IRQ_VEC)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .hi_wr_i    (hi_wr_i),
  .step_i     (step_i),
  .lo_wr_i    (lo_wr_i),
  .lo_data_i  (lo_data_i),
  .jump_i     (jump_i),
  .call_i     (call_i),
  .op_field_i (op_field_i),
  .ret_i      (ret_i),
  .irq_i      (irq_i),
  .pc         (pc_q),
  .hi         (hi_q)
);

// File: tb/pc_ring_ctrl_tb_top.sv
`timescale 1ns/1ps
module pc_ring_ctrl_tb_top;

  logic        clk;
  logic        rst_n;
  logic        hi_wr_i;
  logic [4:0]  hi_data_i;
  logic        step_i;
  logic        lo_wr_i;
  logic [7:0]  lo_data_i;
  logic        jump_i;
  logic        call_i;
  logic [10:0] op_field_i;
  logic        ret_i;
  logic        irq_i;
  logic [12:0] pc_o;
  logic [10:0] fetch_addr_o;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  pc_ring_ctrl dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .hi_wr_i      (hi_wr_i),
    .hi_data_i    (hi_data_i),
    .step_i       (step_i),
    .lo_wr_i      (lo_wr_i),
    .lo_data_i    (lo_data_i),
    .jump_i       (jump_i),
    .call_i       (call_i),
    .op_field_i   (op_field_i),
    .ret_i        (ret_i),
    .irq_i        (irq_i),
    .pc_o         (pc_o),
    .fetch_addr_o (fetch_addr_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    hi_wr_i = 0; hi_data_i = '0; step_i = 0; lo_wr_i = 0; lo_data_i = '0;
    jump_i = 0; call_i = 0; op_field_i = '0; ret_i = 0; irq_i = 0;
  endtask

  // Apply the driven strobes for one edge, sample 1 ns later, then clear
  task automatic cyc();
    @(posedge clk);
    #1;
    idle_inputs();
  endtask

  task automatic t_reset();
    rst_n = 0;
    idle_inputs();
    repeat (3) @(posedge clk);
    #1;
    chk("R1 pc in reset", pc_o, 13'h0000);
    rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 pc after release", pc_o, 13'h0000);
    lo_wr_i = 1; lo_data_i = 8'h00; cyc();
    chk("R1 latch zero after reset", pc_o, 13'h0000);
  endtask

  task automatic t_step();
    for (int i = 0; i < 3; i++) begin
      step_i = 1; cyc();
    end
    chk("R2 three steps", pc_o, 13'h0003);
    hi_wr_i = 1; hi_data_i = 5'h1F; cyc();
    chk("R11 latch write keeps pc", pc_o, 13'h0003);
    lo_wr_i = 1; lo_data_i = 8'hFF; cyc();
    chk("R3 low write full latch", pc_o, 13'h1FFF);
    chk("R9 fetch aliases", {2'b00, fetch_addr_o}, 13'h07FF);
    step_i = 1; cyc();
    chk("R2 wrap to zero", pc_o, 13'h0000);
  endtask

  task automatic t_lowr();
    hi_wr_i = 1; hi_data_i = 5'h0A; cyc();
    chk("R11 latch write keeps pc", pc_o, 13'h0000);
    cyc();
    chk("R11 idle hold", pc_o, 13'h0000);
    lo_wr_i = 1; lo_data_i = 8'h34; cyc();
    chk("R3 low write", pc_o, 13'h0A34);
    chk("R9 fetch address", {2'b00, fetch_addr_o}, 13'h0234);
  endtask

  task automatic t_call_jump_ret();
    // latch 0x0A: bits [4:3] = 01, page bits for PC[12:11]
    jump_i = 1; op_field_i = 11'h155; cyc();
    chk("R4 jump target", pc_o, 13'h0955);
    call_i = 1; op_field_i = 11'h020; cyc();
    chk("R5 call target", pc_o, 13'h0820);
    jump_i = 1; op_field_i = 11'h7FF; cyc();
    chk("R4 second jump", pc_o, 13'h0FFF);
    ret_i = 1; cyc();
    chk("R4 R5 return skips jump", pc_o, 13'h0956);
    lo_wr_i = 1; lo_data_i = 8'h00; cyc();
    chk("R7 latch kept over push and pop", pc_o, 13'h0A00);
  endtask

  task automatic t_irq();
    step_i = 1; cyc();
    irq_i = 1; cyc();
    chk("R6 interrupt vector", pc_o, 13'h0004);
    step_i = 1; cyc();
    ret_i = 1; cyc();
    chk("R6 pushed current pc", pc_o, 13'h0A01);
  endtask

  task automatic t_priority();
    irq_i = 1; ret_i = 1; call_i = 1; jump_i = 1; lo_wr_i = 1; step_i = 1;
    op_field_i = 11'h100; lo_data_i = 8'h77; cyc();
    chk("R10 interrupt wins", pc_o, 13'h0004);
    ret_i = 1; call_i = 1; jump_i = 1; lo_wr_i = 1; step_i = 1;
    op_field_i = 11'h100; lo_data_i = 8'h77; cyc();
    chk("R10 return wins", pc_o, 13'h0A01);
    call_i = 1; jump_i = 1; lo_wr_i = 1; step_i = 1;
    op_field_i = 11'h100; lo_data_i = 8'h77; cyc();
    chk("R10 call wins", pc_o, 13'h0900);
    jump_i = 1; lo_wr_i = 1; step_i = 1;
    op_field_i = 11'h0AA; lo_data_i = 8'h77; cyc();
    chk("R10 jump wins", pc_o, 13'h08AA);
    lo_wr_i = 1; step_i = 1; lo_data_i = 8'h77; cyc();
    chk("R10 low write wins", pc_o, 13'h0A77);
    ret_i = 1; cyc();
    chk("R10 call pushed once", pc_o, 13'h0A02);
  endtask

  function automatic logic [12:0] pushed(input int k);
    if (k == 1) return 13'h0A03;
    return 13'((k - 1) * 13'h040 + 1);
  endfunction

  task automatic t_ring();
    hi_wr_i = 1; hi_data_i = 5'h00; cyc();
    step_i = 1; cyc(); // pc 0x0A02 -> 0x0A03? no: step first
    chk("R2 step before ring", pc_o, 13'h0A03);
    // undo: call pushes pc+1; align so first push is 0x0A03
    lo_wr_i = 1; lo_data_i = 8'h02; cyc();
    chk("R3 page from new latch", pc_o, 13'h0002);
    jump_i = 1; op_field_i = 11'h202; cyc();
    chk("R4 jump page zero", pc_o, 13'h0202);
    // Re-enter the expected start 0x0A02 with latch 0x0A then clear it
    hi_wr_i = 1; hi_data_i = 5'h0A; cyc();
    lo_wr_i = 1; lo_data_i = 8'h02; cyc();
    hi_wr_i = 1; hi_data_i = 5'h00; cyc();
    chk("R11 pc before ring", pc_o, 13'h0A02);
    for (int k = 1; k <= 9; k++) begin
      call_i = 1; op_field_i = 11'(k * 'h40); cyc();
      chk("R5 ring call target", pc_o, 13'(k * 'h40));
    end
    for (int k = 9; k >= 2; k--) begin
      ret_i = 1; cyc();
      chk("R8 ring return order", pc_o, pushed(k));
    end
    ret_i = 1; cyc();
    chk("R8 ninth push overwrote first", pc_o, pushed(9));
  endtask

  initial begin
    idle_inputs();
    t_reset();
    t_step();
    t_lowr();
    t_call_jump_ret();
    t_irq();
    t_priority();
    t_ring();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule